// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target

This block is the target side of a two-wire serial memory bus, placed in front of a small internal byte array. The system clock runs much faster than the bus clock. SCL and SDA are brought in through synchronisers, and start and stop conditions and clock edges are recognised from the synchronised values. SDA is open-drain: the block only pulls it low, through `sda_oe_o`, or releases it.

A bus controller can write one byte or a burst of bytes that stays within one page. It can read from the current internal pointer, load the pointer with a dummy write and then read after a repeated start, and stream bytes for as long as it acknowledges each one. After a stop that ends a successful write, the block models the internally timed programming cycle with a busy counter. During that cycle it ignores the bus completely, so a controller can poll with address words until one is acknowledged. A write-protect input blocks every array update.

Top module: `ee2w_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start condition: it begins reception of an address word with the bit count cleared. A rising SDA while SCL is high is a stop condition: it returns the block to idle with SDA released.
- R2: The address word is received MSB first. Bits 7..4 must equal 4'b1010 and bits 3..1 must equal `addr_pins_i[2:0]`. Bit 0 is the read/write flag, and 1 selects a read. On a mismatch the block gives no acknowledge and does not drive SDA until the next start.
- R3: After reset `sda_oe_o` is 0. For a matching address word, a word address and each data byte, the block drives SDA low for the whole ninth clock. SDA is only pulled low while SCL is low.
- R4: In a write, each data byte is stored at the internal pointer. Only the pointer bits below the page size (PAGE_BYTES, 8 by default) then increment, so a burst that runs past the end of a page wraps to the start of the same page and overwrites earlier bytes.
- R5: A read sends the byte at the internal pointer, MSB first, driven after SCL falls, and then increments the whole pointer. A current-address read uses the pointer left by the previous operation. The pointer wraps from the last byte (0xFF) to byte 0x00.
- R6: A random read is a word-address write (which loads the pointer) followed by a repeated start and an address word with the read flag set. The first byte sent comes from the loaded address.
- R7: A stop that ends a write in which at least one byte was stored starts a busy period of BUSY_CYCLES system clocks. During that period start conditions and address words are ignored and SDA is never driven. After it, address words are acknowledged again.
- R8: While `wp_i` is 1, data bytes are still acknowledged but the array is not changed, and the following stop starts no busy period.
- R9: A start that arrives in the middle of a byte aborts that byte. The pointer is not loaded, and the next address word is received normally.
- R10: During a read, a 0 from the controller in the ninth clock makes the block send the next byte. A 1 ends the read: SDA stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins_i | input | 3 | Hardwired address selection, compared with address bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks all array updates |

## Verification
The bench polls right after a write. A design that did not go silent for the busy period would acknowledge this early poll, and one that never left it would refuse the poll made after the period. It writes ten bytes starting two before a page end and reads the page back. A design that carried the whole pointer would spill into the next page, and one that wrapped to 0 would corrupt page zero.

A sequential read is run across 0xFF, followed by a current-address read, which catches wrong pointer wrap or a missing pointer increment. A start is injected mid-byte, which shows whether a stale bit count is left behind. A clock pulse is sent after a controller non-acknowledge, which shows whether the block keeps driving data it should have stopped. Write-protected bursts are followed by an immediate poll and a readback, which separates "acknowledged but not stored" from either of the other two behaviours.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} st_e;
  typedef enum logic [1:0] {RL_DEV, RL_WADDR, RL_DATA} role_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // pipe[STAGES-1] is the synchronised value, pipe[STAGES] the previous one
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_p[STAGES-1] & ~scl_p[STAGES];
  assign scl_fall_o = ~scl_p[STAGES-1] & scl_p[STAGES];
  assign start_o    = scl_p[STAGES-1] & scl_p[STAGES] & sda_p[STAGES] & ~sda_p[STAGES-1];
  assign stop_o     = scl_p[STAGES-1] & scl_p[STAGES] & ~sda_p[STAGES] & sda_p[STAGES-1];
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_pins_i,
  input  logic       wp_i
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  ee2w_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  st_e            state;
  role_e          role;
  logic [3:0]     bit_cnt;
  logic [7:0]     shreg, tx_sh;
  logic [AW-1:0]  ptr, ptr_pg;
  logic [BCW-1:0] busy_cnt;
  logic           rnw_q, wr_pend, oe_q;
  logic [7:0]     rdata;
  logic           rx_done, wr_en, dev_hit;

  assign rx_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign wr_en   = rx_done && (role == RL_DATA) && !wp_i;
  assign dev_hit = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == addr_pins_i);
  assign ptr_pg  = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};  // write wraps inside page
  assign sda_oe_o = oe_q;

  ee2w_array #(.DEPTH(MEM_BYTES)) u_array (
    .clk_i, .rst_ni, .we_i(wr_en), .addr_i(ptr), .wdata_i(shreg), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      role     <= RL_DEV;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      busy_cnt <= '0;
      rnw_q    <= 1'b0;
      wr_pend  <= 1'b0;
      oe_q     <= 1'b0;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
      state    <= ST_IDLE;
      oe_q     <= 1'b0;
    end else if (stop) begin
      state   <= ST_IDLE;
      oe_q    <= 1'b0;
      wr_pend <= 1'b0;
      if (wr_pend) busy_cnt <= BUSY_CYCLES[BCW-1:0];
    end else if (start) begin
      state   <= ST_RX;
      role    <= RL_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (rx_done) begin
            if (role == RL_DEV) begin
              if (dev_hit) begin
                rnw_q <= shreg[0];
                oe_q  <= 1'b1;
                state <= ST_RX_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (role == RL_WADDR) ptr <= shreg[AW-1:0];
              if (wr_en) begin
                ptr     <= ptr_pg;
                wr_pend <= 1'b1;
              end
              oe_q  <= 1'b1;
              state <= ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (role == RL_DEV && rnw_q) begin
              tx_sh <= rdata;
              oe_q  <= ~rdata[7];
              ptr   <= ptr + 1'b1;
              state <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              role  <= (role == RL_DEV) ? RL_WADDR : RL_DATA;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              oe_q  <= 1'b0;
              state <= ST_TX_ACK;
            end else begin
              oe_q  <= ~tx_sh[6];
              tx_sh <= {tx_sh[6:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;  // controller declined more data
          end else if (scl_fall) begin
            bit_cnt <= '0;
            tx_sh   <= rdata;
            oe_q    <= ~rdata[7];
            ptr     <= ptr + 1'b1;
            state   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: the line is only pulled low while the bus clock is low
  a_r3_drive_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  // R7: silent and counting down while busy
  a_r7_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt != '0) |-> !sda_oe_o);
  a_r7_busy_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1));
  // R4: a stored byte never moves the pointer off its page
  a_r4_page_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW])));
  // R1: an accepted start clears reception
  a_r1_start_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !stop && busy_cnt == '0) |=> (state == ST_RX && bit_cnt == 4'd0 && role == RL_DEV));
  // R8: a pending write only arises with protection off
  a_r8_wp_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_pend) |-> !$past(wp_i));
endmodule

// File: tb/tb_ee2w_slave.sv
module tb_ee2w_slave;
  localparam int BUSY = 300;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  ee2w_slave #(.MEM_BYTES(256), .PAGE_BYTES(8), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_pins_i(pins), .wp_i(wp)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [0:255];
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic rw); return {4'b1010, pins, rw}; endfunction
  function automatic logic [7:0] pnext(input logic [7:0] a); return {a[7:3], a[2:0] + 3'd1}; endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask
  task automatic bus_stop();
    wt(2); sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wt(2); sda_m = b[i]; wt(H - 2); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    wt(2); sda_m = 1'b1; wt(H - 2); scl_m = 1'b1; wt(H / 2); ack = sda_line; wt(H / 2); scl_m = 1'b0;
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_m = 1'b1; wt(H / 2); b[i] = sda_line; wt(H / 2); scl_m = 1'b0;
    end
    wt(2); sda_m = ~mack; wt(H - 2); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] p = a;
    bus_start();
    send_byte(dev(1'b0), ack); chk({req, " dev ack"}, ack, 0);
    send_byte(a, ack);         chk({req, " waddr ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk({req, " data ack"}, ack, 0);
      if (!wp) model[p] = wbuf[i];
      p = pnext(p);
    end
    bus_stop();
  endtask

  // random read when rnd=1, else current-address read; exp_a is the expected first address
  task automatic do_read(input bit rnd, input logic [7:0] a, input int n,
                         input logic [7:0] exp_a, input string req);
    logic ack;
    bus_start();
    if (rnd) begin
      send_byte(dev(1'b0), ack); chk({req, " dummy dev ack"}, ack, 0);
      send_byte(a, ack);         chk({req, " dummy waddr ack"}, ack, 0);
      bus_start();
    end
    send_byte(dev(1'b1), ack); chk({req, " read dev ack"}, ack, 0);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
    for (int i = 0; i < n; i++) chk({req, " data"}, rbuf[i], model[8'(exp_a + i)]);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    void'($urandom(32'h5eed));
    wt(5);
    chk("R3 reset release", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    chk("R3 idle release", sda_oe, 0);

    // R2: wrong pins and wrong type get no acknowledge
    bus_start(); send_byte(8'hA0, ack); chk("R2 pin mismatch nack", ack, 1); bus_stop();
    bus_start(); send_byte({4'b0110, pins, 1'b0}, ack); chk("R2 type mismatch nack", ack, 1); bus_stop();

    // R7: poll during busy gets nothing, poll afterwards is acknowledged
    wbuf[0] = 8'h3C;
    do_write(8'h05, 1, "R4 byte write");
    wt(4);
    bus_start(); send_byte(dev(1'b0), ack); chk("R7 poll while busy nack", ack, 1); bus_stop();
    wt(BUSY);
    bus_start(); send_byte(dev(1'b0), ack); chk("R7 poll after busy ack", ack, 0); bus_stop();
    do_read(1'b1, 8'h05, 1, 8'h05, "R6 random read");

    // R4: ten bytes from offset 6 of page 0x10 wrap within the page
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hD0 + 8'(i);
    do_write(8'h16, 10, "R4 page wrap");
    wt(BUSY + 20);
    do_read(1'b1, 8'h10, 9, 8'h10, "R4 page wrap readback");
    chk("R4 next page untouched", rbuf[8], 0);
    chk("R4 wrapped byte", rbuf[6], 8'hD8);

    // R5: sequential read across 0xFF, then current-address read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(8'hFE, 2, "R4 top write"); wt(BUSY + 20);
    wbuf[0] = 8'h33;
    do_write(8'h00, 1, "R4 bottom write"); wt(BUSY + 20);
    do_read(1'b1, 8'hFE, 3, 8'hFE, "R5 wrap read");
    do_read(1'b0, 8'h00, 1, 8'h01, "R5 current addr");

    // R9: start in the middle of a word address aborts it
    bus_start(); send_byte(dev(1'b0), ack); chk("R9 dev ack", ack, 0);
    send_bits(8'h40, 4);
    bus_start(); send_byte(dev(1'b1), ack); chk("R9 dev after abort ack", ack, 0);
    recv_byte(1'b0, b); bus_stop();
    chk("R9 pointer kept", b, model[8'h02]);

    // R10: after a controller nack the line stays released
    bus_start(); send_byte(dev(1'b1), ack); chk("R10 dev ack", ack, 0);
    recv_byte(1'b0, b); chk("R10 data", b, model[8'h03]);
    recv_byte(1'b0, b); chk("R10 silent after nack", b, 8'hFF);
    bus_stop();
    bus_start(); send_byte(dev(1'b1), ack); chk("R1 new start after stop ack", ack, 0);
    recv_byte(1'b0, b); bus_stop();
    chk("R1 data after restart", b, model[8'h04]);

    // R8: protected write acked, not stored, no busy
    wp = 1'b1;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    do_write(8'h40, 2, "R8 protected write");
    wt(4);
    bus_start(); send_byte(dev(1'b0), ack); chk("R8 no busy after protected write", ack, 0); bus_stop();
    wp = 1'b0;
    do_read(1'b1, 8'h40, 2, 8'h40, "R8 array unchanged");

    // constrained random writes and reads
    for (int it = 0; it < 12; it++) begin
      logic [7:0] a = 8'($urandom);
      int n = 1 + int'($urandom % 10);
      wp = (($urandom % 4) == 0);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, wp ? "R8 random" : "R4 random");
      if (!wp) wt(BUSY + 20);
      wp = 1'b0;
      do_read(1'b1, {a[7:3], 3'd0}, 8, {a[7:3], 3'd0}, "R5 random readback");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule